// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Match Detect

The block keeps time in a slow clock domain, normally a 32.768 kHz crystal clock. A fixed divide-by-128 prescaler turns that clock into a 256 Hz advance tick. Each tick adds one to a 40-bit up-counter that software can preload one byte at a time.

A 40-bit compare value is written through the same byte-wide port. Every counter bit is checked against its compare bit. The block exposes the resulting 40 equality flags and a registered match flag, which is set when all 40 flags agree. The match flag stays set until software clears it. A second copy of the flag drives a power-supply monitor.

A small control write starts or halts counting and clears the match flag. The host bus and the crossing into the host domain sit outside this block.

Top module: `rtc_match_core`

## Requirements
- R1: While running, `tick_o` is high for exactly one cycle in every 128 clock cycles. The counter adds one (modulo 2^40) at the clock edge that ends a tick cycle.
- R2: After reset, the count is zero and the compare value is all ones. Counting is halted and `match_o` is low.
- R3: A write with `wr_en_i`=1, `wr_sel_cmp_i`=0 and `wr_idx_i`=k (k in 0..4) replaces count bits [8k+7:8k] with `wr_data_i` at the next edge. The other bytes are kept. The write wins over a tick in that cycle, and it restarts the prescaler, so the next advance comes 128 edges later. An index of 5 to 7 changes nothing.
- R4: A write with `wr_sel_cmp_i`=1 replaces byte k of the compare value in the same way. It does not disturb the count or the prescaler phase. An index of 5 to 7 changes nothing.
- R5: A control write (`ctrl_we_i`=1) loads `ctrl_run_i` into the run state. While halted, the count and the prescaler phase hold.
- R6: `eq_bits_o[i]` is 1 exactly when count bit i equals compare bit i. The flags follow the registered values in the same cycle.
- R7: `match_o` rises at the edge after the count equals the compare value. It stays high until a control write with `ctrl_clr_i`=1 lands on an edge where the two differ. At an edge where they are equal, setting wins over clearing.
- R8: `match_psm_o` equals `match_o` in every cycle.
- R9: The count rolls over from all ones to zero. The rollover raises no flag, and `match_o` stays low unless the compare value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_run_i | input | 1 | Run value loaded by a control write |
| ctrl_clr_i | input | 1 | Clear the match flag on a control write |
| wr_en_i | input | 1 | Byte write strobe |
| wr_sel_cmp_i | input | 1 | 0: count byte, 1: compare byte |
| wr_idx_i | input | 3 | Byte index, 0 is the least significant |
| wr_data_i | input | 8 | Byte value |
| tick_o | output | 1 | Prescaler tick; the count advances at the end of this cycle |
| count_o | output | 40 | Current count |
| eq_bits_o | output | 40 | Per-bit equality flags |
| match_o | output | 1 | Sticky match flag |
| match_psm_o | output | 1 | Copy of the match flag for the supply monitor |

## Verification
A control write or byte write sampled at edge E shows up in `count_o` and `eq_bits_o` right after E. A running counter next advances at edge E+128: `tick_o` is high in the cycle before that edge. `match_o` and `match_psm_o` follow equality one edge later. The bench keeps a behavioural model that it updates at each rising edge from the inputs it drove. It compares all outputs against that model at every falling edge, once every register on the path has settled. Directed checks placed at the same falling edges cover reset, clearing with set priority, halting, ignored indices and rollover.

// File: rtl/rtc_match_pkg.sv
package rtc_match_pkg;
  typedef enum logic {
    TGT_COUNT = 1'b0,
    TGT_CMP   = 1'b1
  } wr_target_e;

  // true when byte index idx addresses lane
  function automatic logic lane_hit(input int unsigned idx, input int unsigned lane);
    return idx == lane;
  endfunction

  // next prescaler phase: restart on load, hold when halted, wrap at div-1
  function automatic int unsigned phase_next(input int unsigned ph, input int unsigned div,
                                             input logic run, input logic restart);
    if (restart) return 0;
    if (!run) return ph;
    return (ph == div - 1) ? 0 : ph + 1;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PS_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PS_W-1:0] phase_q;
  logic [PS_W-1:0] phase_d;

  always_comb begin
    phase_d = PS_W'(rtc_match_pkg::phase_next(32'(phase_q), DIV, run_i, restart_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign tick_o = run_i && (phase_q == PS_W'(DIV - 1));
endmodule

// File: rtl/rtc_lane_reg.sv
module rtc_lane_reg #(
  parameter int unsigned W      = 40,
  parameter int unsigned BYTE_W = 8,
  parameter bit          INC_EN = 1'b1,
  parameter bit          RST_ONES = 1'b0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          inc_i,
  input  logic                          wr_en_i,
  input  logic [$clog2(W/BYTE_W)-1:0]   wr_idx_i,
  input  logic [BYTE_W-1:0]             wr_data_i,
  output logic [W-1:0]                  val_o,
  output logic                          load_o
);
  localparam int unsigned NB    = W / BYTE_W;
  localparam int unsigned IDX_W = $clog2(NB);
  localparam logic [W-1:0] RST_VAL = RST_ONES ? '1 : '0;

  logic [NB-1:0] lane_we;
  logic [W-1:0]  val_q;
  logic [W-1:0]  val_d;
  logic [W-1:0]  wr_word;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_we[g] = wr_en_i && rtc_match_pkg::lane_hit(32'(wr_idx_i), g);
    assign wr_word[g*BYTE_W +: BYTE_W] = lane_we[g] ? wr_data_i : val_q[g*BYTE_W +: BYTE_W];
  end

  assign load_o = |lane_we;

  always_comb begin
    if (load_o)                val_d = wr_word;
    else if (INC_EN && inc_i)  val_d = val_q + W'(1);
    else                       val_d = val_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= RST_VAL;
    else         val_q <= val_d;
  end

  assign val_o = val_q;

  logic unused_idx;
  assign unused_idx = ^{IDX_W'(0)};
endmodule

// File: rtl/rtc_matcher.sv
module rtc_matcher #(
  parameter int unsigned W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         clr_i,
  output logic [W-1:0] eq_o,
  output logic         all_eq_o,
  output logic         match_o
);
  logic match_q;

  assign eq_o     = ~(cnt_i ^ cmp_i);
  assign all_eq_o = &eq_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       match_q <= 1'b0;
    else if (all_eq_o) match_q <= 1'b1;
    else if (clr_i)    match_q <= 1'b0;
  end

  assign match_o = match_q;
endmodule

// File: rtl/rtc_match_core.sv
module rtc_match_core #(
  parameter int unsigned CNT_W  = 40,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV    = 128,
  localparam int unsigned NB    = CNT_W / BYTE_W,
  localparam int unsigned IDX_W = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ctrl_run_i,
  input  logic              ctrl_clr_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_cmp_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              tick_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  eq_bits_o,
  output logic              match_o,
  output logic              match_psm_o
);
  import rtc_match_pkg::*;

  logic             run_q;
  logic             tick;
  logic             cnt_wr;
  logic             cmp_wr;
  logic             cnt_load;
  logic             cmp_load;
  logic             all_eq;
  logic             clr_req;
  logic [CNT_W-1:0] cmp_val;

  assign cnt_wr  = wr_en_i && (wr_target_e'(wr_sel_cmp_i) == TGT_COUNT);
  assign cmp_wr  = wr_en_i && (wr_target_e'(wr_sel_cmp_i) == TGT_CMP);
  assign clr_req = ctrl_we_i && ctrl_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 1'b0;
    else if (ctrl_we_i) run_q <= ctrl_run_i;
  end

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .restart_i (cnt_load),
    .tick_o    (tick)
  );

  rtc_lane_reg #(.W(CNT_W), .BYTE_W(BYTE_W), .INC_EN(1'b1), .RST_ONES(1'b0)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (tick),
    .wr_en_i   (cnt_wr),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .val_o     (count_o),
    .load_o    (cnt_load)
  );

  rtc_lane_reg #(.W(CNT_W), .BYTE_W(BYTE_W), .INC_EN(1'b0), .RST_ONES(1'b1)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (1'b0),
    .wr_en_i   (cmp_wr),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .val_o     (cmp_val),
    .load_o    (cmp_load)
  );

  rtc_matcher #(.W(CNT_W)) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (count_o),
    .cmp_i    (cmp_val),
    .clr_i    (clr_req),
    .eq_o     (eq_bits_o),
    .all_eq_o (all_eq),
    .match_o  (match_o)
  );

  assign tick_o      = tick;
  assign match_psm_o = match_o;
endmodule

// File: rtl/rtc_match_core_chk.sv
module rtc_match_core_chk #(
  parameter int unsigned CNT_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             run_q,
  input logic             cnt_load,
  input logic             cmp_load,
  input logic             all_eq,
  input logic             clr_req,
  input logic [CNT_W-1:0] count_o,
  input logic             match_o,
  input logic             match_psm_o
);
  AST_TICK_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_load) |=> (count_o == $past(count_o) + CNT_W'(1))); // R1
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick); // R1
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !cnt_load) |=> $stable(count_o)); // R5
  AST_CMP_WRITE_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_load && !cnt_load && !tick) |=> $stable(count_o)); // R4
  AST_MATCH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_eq |=> match_o); // R7
  AST_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !clr_req) |=> match_o); // R7
  AST_MATCH_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> $past(all_eq)); // R7
  AST_PSM_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_psm_o == match_o); // R8
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_load && (&count_o)) |=> (count_o == '0)); // R9
endmodule

bind rtc_match_core rtc_match_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick        (tick),
  .run_q       (run_q),
  .cnt_load    (cnt_load),
  .cmp_load    (cmp_load),
  .all_eq      (all_eq),
  .clr_req     (clr_req),
  .count_o     (count_o),
  .match_o     (match_o),
  .match_psm_o (match_psm_o)
);

// File: tb/rtc_match_core_bench.sv
`timescale 1ns/1ps
module rtc_match_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, ctrl_run = 1'b0, ctrl_clr = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [7:0]  wr_data = '0;
  logic        tick;
  logic [39:0] count, eqb;
  logic        match, psm;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_match_core u_rtc_match_core (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_run_i(ctrl_run),
    .ctrl_clr_i(ctrl_clr), .wr_en_i(wr_en), .wr_sel_cmp_i(wr_sel), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .tick_o(tick), .count_o(count), .eq_bits_o(eqb),
    .match_o(match), .match_psm_o(psm));

  // behavioural reference model
  localparam logic [63:0] MASK = (64'd1 << 40) - 64'd1;
  logic [63:0] m_cnt, m_cmp;
  int          m_ps;
  bit          m_run, m_match;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = MASK; m_ps = 0; m_run = 0; m_match = 0;
    end else begin
      bit eq_now, tk, cload;
      eq_now = (m_cnt == m_cmp);
      tk     = m_run && (m_ps == 127);
      cload  = wr_en && !wr_sel && (wr_idx < 5);
      if (eq_now) m_match = 1;
      else if (ctrl_we && ctrl_clr) m_match = 0;
      if (cload) begin
        m_cnt = (m_cnt & ~(64'hFF << (8 * wr_idx))) | (64'(wr_data) << (8 * wr_idx));
        m_ps = 0;
      end else begin
        if (tk) m_cnt = (m_cnt + 1) & MASK;
        if (m_run) m_ps = (m_ps + 1) % 128;
      end
      if (wr_en && wr_sel && (wr_idx < 5))
        m_cmp = (m_cmp & ~(64'hFF << (8 * wr_idx))) | (64'(wr_data) << (8 * wr_idx));
      if (ctrl_we) m_run = ctrl_run;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 tick", 64'(tick), 64'(m_run && m_ps == 127));
      chk("R3 count", 64'(count), m_cnt);
      chk("R6 eq_bits", 64'(eqb), ~(m_cnt ^ m_cmp) & MASK);
      chk("R7 match", 64'(match), 64'(m_match));
      chk("R8 psm copy", 64'(psm), 64'(match));
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctrl(input bit run, input bit clr);
    ctrl_we = 1; ctrl_run = run; ctrl_clr = clr;
    @(negedge clk);
    ctrl_we = 0; ctrl_clr = 0;
  endtask

  task automatic wr(input bit sel, input int idx, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load40(input bit sel, input logic [39:0] v);
    for (int k = 0; k < 5; k++) wr(sel, k, v[8*k +: 8]);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    cycles(3);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset count", 64'(count), 0);
    chk("R2 reset match", 64'(match), 0);
    chk("R2 reset eq (cmp all ones)", 64'(eqb), 0);
    chk("R2 reset halted", 64'(tick), 0);

    // compare value 3, run, expect match after the third advance
    load40(1, 40'd3);
    ctrl(1, 0);
    cycles(127);
    chk("R1 first advance pending", 64'(count), 0);
    cycles(1);
    chk("R1 first advance", 64'(count), 1);
    cycles(2 * 128 + 1);
    chk("R7 match raised", 64'(match), 1);
    chk("R8 psm raised", 64'(psm), 1);
    ctrl(1, 1);
    chk("R7 set wins over clear", 64'(match), 1);
    cycles(130);
    ctrl(1, 1);
    chk("R7 cleared", 64'(match), 0);

    // halt freezes count
    ctrl(0, 0);
    begin
      logic [39:0] held;
      held = count;
      cycles(300);
      chk("R5 halted count holds", 64'(count), 64'(held));
    end

    // out of range indices ignored, rollover
    load40(0, '1);
    wr(0, 5, 8'h00);
    chk("R3 index 5 ignored", 64'(count), 64'hFF_FFFF_FFFF);
    load40(1, 40'h12_3456_789A);
    wr(1, 6, 8'h00);
    chk("R4 index 6 ignored", 64'(eqb), ~(64'hFF_FFFF_FFFF ^ 64'h12_3456_789A) & MASK);
    ctrl(1, 0);
    cycles(129);
    chk("R9 rollover to zero", 64'(count), 0);
    chk("R9 rollover no match", 64'(match), 0);

    // mid-phase preload restarts prescaler, then match on a high value
    cycles(50);
    wr(0, 0, 8'h99);
    wr(0, 1, 8'h78);
    wr(0, 2, 8'h56);
    wr(0, 3, 8'h34);
    wr(0, 4, 8'h12);
    chk("R3 byte preload", 64'(count), 64'h12_3456_7899);
    cycles(127);
    chk("R3 phase restarted", 64'(count), 64'h12_3456_7899);
    cycles(2);
    chk("R7 match on high value", 64'(match), 1);

    cycles(4);
    finish_run();
  end
endmodule